// File: doc/BRIEF.md
# Byte-Masked Data Fuzzing Unit

This block mutates a wide data word one byte at a time. Each input word comes with a mask that has one bit per byte. A byte whose mask bit is set leaves the block XORed with a pseudo-random byte. A byte whose mask bit is clear passes through untouched. The caller can therefore protect the structured fields of a record, such as headers and lengths, and disturb only the payload bytes it chooses.

The random word is built from one small 8-bit linear feedback shift register per byte lane, all running side by side. No wide generator or multiplier is used. Every lane steps exactly once for each word the block accepts, so a consumer that knows the seeds can reproduce the whole mutation stream. A seed port reloads all lanes at once. The result goes through a single output register with a valid/ready handshake, and that register can stall.

Top module: `byte_fuzz_unit`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For a word accepted while lane i holds state s_i, output byte i (bits [8i+7:8i]) equals input byte i XOR s_i when mask bit i is 1.
- R3: Output byte i equals input byte i when mask bit i is 0, so an all-zero mask returns the input word exactly.
- R4: Every lane takes one step `s <= {s[6:0], s[7]^s[5]^s[4]^s[3]}` (polynomial x^8+x^6+x^5+x^4+1) for each accepted word, whatever the mask. Lanes keep their state in every other cycle, including stalled cycles where the input is valid but not accepted.
- R5: After reset, lane i holds (37*i+1) mod 256. If that value would be 0, the lane holds 8'h5A instead.
- R6: A cycle with `seed_load` high loads lane i with byte i of `seed_value`. A zero byte is replaced by that lane's reset seed from R5, so no lane ever holds 0.
- R7: An accepted word appears on `out_data` with `out_valid` high one cycle later. While `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R8: `in_ready` is high exactly when the output register is empty or is being drained in the same cycle.
- R9: When `seed_load` and an accepted word fall in the same cycle, the word is mutated with the lane states from before the load, and the new seeds apply from the next word onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and mask are present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | LANES*8 | Data word to mutate |
| in_mask | input | LANES | One bit per byte; 1 means the byte is fuzzed |
| seed_load | input | 1 | Reload all lanes from `seed_value` |
| seed_value | input | LANES*8 | One seed byte per lane |
| out_valid | output | 1 | Result register holds a word |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | LANES*8 | Mutated word |

## Verification
A zero data word with a full mask exposes the raw lane states, which pins down the reset seeds, the seed reload and the step rule. An all-zero mask on random data shows that the block is transparent while the lanes keep advancing. A single mask bit walked across all 32 positions, followed by random masks on random data, shows that each mask bit steers only its own byte to its own lane. Idle gaps, a stalled output with a pending input, and a seed load coinciding with an accepted word separate lanes that step on every word from lanes that also step when they should hold.

// File: rtl/fz_pkg.sv
package fz_pkg;

  localparam int LANE_W = 8;

  // Reset seed of one lane; never zero.
  function automatic logic [LANE_W-1:0] lane_default(input int idx);
    logic [LANE_W-1:0] v;
    v = LANE_W'((idx * 37 + 1) % 256);
    if (v == '0) v = 8'h5A;
    return v;
  endfunction

  // One step of the lane generator, polynomial x^8+x^6+x^5+x^4+1.
  function automatic logic [LANE_W-1:0] lane_step(input logic [LANE_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/fz_lane.sv
module fz_lane
  import fz_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [LANE_W-1:0] seed,
  output logic [LANE_W-1:0] state
);

  localparam logic [LANE_W-1:0] DFLT = lane_default(IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DFLT;
    end else if (load) begin
      state <= (seed == '0) ? DFLT : seed;
    end else if (adv) begin
      state <= lane_step(state);
    end
  end

endmodule

// File: rtl/fz_outreg.sv
module fz_outreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         drain,
  output logic         can_take,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  assign can_take = !q_valid || drain;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= d;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/byte_fuzz_unit.sv
module byte_fuzz_unit
  import fz_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_mask,
  input  logic                    seed_load,
  input  logic [LANES*LANE_W-1:0] seed_value,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);

  localparam int DATA_W = LANES * LANE_W;

  logic              accept;
  logic [DATA_W-1:0] rand_word;
  logic [DATA_W-1:0] mixed;

  assign accept = in_valid && in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fz_lane #(.IDX(i)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .adv   (accept),
      .load  (seed_load),
      .seed  (seed_value[i*LANE_W +: LANE_W]),
      .state (rand_word[i*LANE_W +: LANE_W])
    );

    assign mixed[i*LANE_W +: LANE_W] = in_mask[i]
      ? (in_data[i*LANE_W +: LANE_W] ^ rand_word[i*LANE_W +: LANE_W])
      : in_data[i*LANE_W +: LANE_W];
  end

  fz_outreg #(.W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .d        (mixed),
    .drain    (out_ready),
    .can_take (in_ready),
    .q_valid  (out_valid),
    .q_data   (out_data)
  );

endmodule

// File: rtl/fz_checker.sv
module fz_checker #(
  parameter int LANES = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [LANES*8-1:0] in_data,
  input logic [LANES-1:0]   in_mask,
  input logic               seed_load,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES*8-1:0] out_data,
  input logic [LANES*8-1:0] rand_word
);

  logic               acc;
  logic [LANES*8-1:0] wide_mask;
  logic               any_zero_lane;

  assign acc = in_valid && in_ready;

  always_comb begin
    any_zero_lane = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      wide_mask[i*8 +: 8] = {8{in_mask[i]}};
      if (rand_word[i*8 +: 8] == 8'h00) any_zero_lane = 1'b1;
    end
  end

  // R1: the output is empty in the first cycle after reset
  assert_empty_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R2 and R3: output differs from input only in masked bytes, by the lane value
  assert_byte_mix_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> ((out_data ^ $past(in_data)) == ($past(rand_word) & $past(wide_mask))));

  // R4: the lanes hold when nothing is accepted or loaded
  assert_lanes_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!acc && !seed_load) |=> $stable(rand_word));

  // R6: no lane ever holds zero
  assert_no_zero_lane_R6: assert property (@(posedge clk) disable iff (rst)
    !any_zero_lane);

  // R7: one cycle of latency
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  // R7: a stalled output holds
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: no new word is taken while a full output is not drained
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && !out_ready && in_ready));

endmodule

bind byte_fuzz_unit fz_checker #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_mask    (in_mask),
  .seed_load  (seed_load),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .rand_word  (rand_word)
);

// File: tb/sim_byte_fuzz_unit.sv
module sim_byte_fuzz_unit;

  localparam int N = 32;
  localparam int W = N * 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic [N-1:0] in_mask = '0;
  logic         seed_load = 1'b0;
  logic [W-1:0] seed_value = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  logic [7:0] lane [N];

  always #10 clk = ~clk;

  byte_fuzz_unit #(.LANES(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .seed_load(seed_load),
    .seed_value(seed_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] v;
    v = 8'((i * 37 + 1) % 256);
    return (v == 8'h00) ? 8'h5A : v;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] r = '0;
    for (int k = 0; k < W / 32; k++) r = {r[W-33:0], 32'($urandom)};
    return r;
  endfunction

  function automatic logic [W-1:0] expect_of(input logic [W-1:0] d, input logic [N-1:0] m);
    logic [W-1:0] e = d;
    for (int i = 0; i < N; i++)
      if (m[i]) e[i*8 +: 8] = d[i*8 +: 8] ^ lane[i];
    return e;
  endfunction

  task automatic step_model();
    for (int i = 0; i < N; i++) lane[i] = nxt(lane[i]);
  endtask

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One word through the block with out_ready high; checks the result one cycle later.
  task automatic xfer(input logic [W-1:0] d, input logic [N-1:0] m, input string req);
    logic [W-1:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mask = m;
    e = expect_of(d, m);
    @(negedge clk);
    in_valid = 1'b0;
    step_model();
    chk(out_valid == 1'b1 && out_data == e, req, out_data, e);
  endtask

  task automatic load_seed(input logic [W-1:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed_value = s;
    @(negedge clk);
    seed_load = 1'b0;
    for (int i = 0; i < N; i++) lane[i] = (s[i*8 +: 8] == 8'h00) ? dflt(i) : s[i*8 +: 8];
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] a, b, ea, eb, s;
    logic [N-1:0] ma, mb;
    for (int i = 0; i < N; i++) lane[i] = dflt(i);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 during reset", {255'd0, out_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", {254'd0, out_valid, in_ready}, {254'd0, 2'b01});

    // R5 and R2: zero data with full mask exposes the reset seeds
    xfer('0, '1, "R5 reset seeds");

    // R3: all-zero mask is transparent, lanes still step (R4)
    for (int k = 0; k < 4; k++) xfer(rnd(), '0, "R3 zero mask");
    xfer('0, '1, "R4 lanes stepped under zero mask");

    // R2 and R3: walking single mask bit
    for (int k = 0; k < N; k++) xfer(rnd(), N'(1) << k, "R2 walking mask bit");

    // R2 and R3: random data, random masks
    for (int k = 0; k < 40; k++) xfer(rnd(), N'($urandom), "R2 random mask");
    xfer({W/8{8'hFF}}, {N/2{2'b01}}, "R3 alternating mask");

    // R4: idle cycles do not step the lanes
    repeat (5) @(negedge clk);
    xfer('0, '1, "R4 hold while idle");

    // R7 and R8: stalled output with a pending second word
    a = rnd(); ma = N'($urandom);
    b = rnd(); mb = '1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = a; in_mask = ma;
    ea = expect_of(a, ma);
    @(negedge clk);
    step_model();
    in_data = b; in_mask = mb;
    chk(out_valid && out_data == ea, "R7 latency under stall", out_data, ea);
    chk(!in_ready, "R8 ready low when full", {255'd0, in_ready}, '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == ea, "R7 stalled output holds", out_data, ea);
    end
    eb = expect_of(b, mb);
    out_ready = 1'b1;
    #1;
    chk(in_ready, "R8 ready while draining", {255'd0, in_ready}, {255'd0, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    step_model();
    chk(out_valid && out_data == eb, "R4 no step during stall", out_data, eb);
    @(negedge clk);
    chk(!out_valid && in_ready, "R8 empty after drain", {255'd0, out_valid}, '0);

    // R6: seed reload with some zero bytes
    s = rnd();
    s[7:0] = 8'h00; s[5*8 +: 8] = 8'h00; s[31*8 +: 8] = 8'h00;
    load_seed(s);
    xfer('0, '1, "R6 seed load zero substitution");
    xfer(rnd(), N'($urandom), "R6 stream after reload");

    // R9: seed load in the same cycle as an accepted word
    a = rnd(); ma = '1; s = rnd();
    @(negedge clk);
    in_valid = 1'b1; in_data = a; in_mask = ma;
    seed_load = 1'b1; seed_value = s;
    ea = expect_of(a, ma);
    @(negedge clk);
    in_valid = 1'b0; seed_load = 1'b0;
    for (int i = 0; i < N; i++) lane[i] = (s[i*8 +: 8] == 8'h00) ? dflt(i) : s[i*8 +: 8];
    chk(out_valid && out_data == ea, "R9 word uses old lane state", out_data, ea);
    xfer('0, '1, "R9 new seeds apply next");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule